// File: doc/BRIEF.md
# UART Request and Error Interrupt Generator

This block sits next to the receive and transmit paths of a UART and turns their occupancy and error information into level-sensitive request lines. It looks at the receive and transmit FIFO word counts, or at the holding-register flags when the FIFOs are switched off. From these it raises a receive request and a transmit request. Each direction has a two-bit mode field that sends its request to an interrupt line or to a DMA request line, or silences it.

Receive-path error pulses are overrun, parity, framing and break. They are captured into a sticky four-bit status register that software reads. A read strobe clears the register, and an error interrupt is raised while any captured bit is set and the error interrupt enable is 1. The block also reports receive-data-ready, transmit-buffer-empty and transmit-shifter-empty as status levels.

Top module: `uart_req_gen`

## Requirements
- R1: With `fifoEn`=1, the receive request condition is `rxCount` != 0 and `rxCount` >= `rxTrig`. The routed output follows that condition one clock later, and deasserts one clock after the count falls below the trigger.
- R2: With `fifoEn`=1, the transmit request condition is `txCount` <= `txTrig`, routed one clock later. As a result, enabling a direction while the transmit FIFO is empty raises the request on the next clock.
- R3: With `fifoEn`=0, the receive request condition is `rxHoldFull`=1, so the request drops one clock after the holding register is read empty.
- R4: With `fifoEn`=0, the transmit request condition is `txHoldFull`=0.
- R5: Mode encoding per direction: 0 = disabled, 1 = interrupt/polling, 2 = DMA, 3 = disabled. In disabled modes both outputs of that direction are low. A direction's interrupt and DMA outputs are never high together.
- R6: An error pulse sets its `errStatus` bit on the next clock (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break). A set bit stays set until cleared by R7.
- R7: A clock edge with `errRead`=1 clears `errStatus`. Error pulses present in that same cycle are still captured.
- R8: `errIrq` is high exactly when `errIntEn`=1 and any `errStatus` bit is set. All request outputs are levels.
- R9: Status, registered one clock: `rxReady` = (fifoEn ? rxCount!=0 : rxHoldFull); `txBufEmpty` = (fifoEn ? txCount==0 : !txHoldFull); `txShiftEmpty` = `txBufEmpty` and not `txShiftBusy`.
- R10: While `rstN`=0, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | 1 = trigger-level FIFO operation, 0 = holding register |
| rxMode | input | 2 | Receive request routing mode |
| txMode | input | 2 | Transmit request routing mode |
| errIntEn | input | 1 | Error interrupt enable |
| rxTrig | input | CNT_W | Receive trigger level |
| txTrig | input | CNT_W | Transmit trigger level |
| rxCount | input | CNT_W | Words in receive FIFO |
| txCount | input | CNT_W | Words in transmit FIFO |
| rxHoldFull | input | 1 | Receive holding register holds a word |
| txHoldFull | input | 1 | Transmit holding register holds a word |
| txShiftBusy | input | 1 | Transmit shifter is sending |
| errOverrun | input | 1 | Overrun pulse |
| errParity | input | 1 | Parity error pulse |
| errFrame | input | 1 | Framing error pulse |
| errBreak | input | 1 | Break pulse |
| errRead | input | 1 | Error status read strobe |
| rxIrq | output | 1 | Receive interrupt request |
| rxDma | output | 1 | Receive DMA request |
| txIrq | output | 1 | Transmit interrupt request |
| txDma | output | 1 | Transmit DMA request |
| errIrq | output | 1 | Error interrupt |
| errStatus | output | 4 | Captured error bits |
| rxReady | output | 1 | Receive data available |
| txBufEmpty | output | 1 | Transmit buffer empty |
| txShiftEmpty | output | 1 | Transmit buffer and shifter both idle |

## Verification
The assertions assume that the FIFO counts never exceed the FIFO depth. They also assume that a read strobe and error pulses are sampled as ordinary single-cycle inputs, with no relation required between them. Mode values 0 to 3 are all legal. The stimulus draws the counts and triggers from 0 to the depth, and it exercises every mode code, including the reserved one. It mixes read strobes with simultaneous error pulses, so that the clear-versus-capture priority is covered alongside the trigger boundaries.

// File: rtl/uart_req_pkg.sv
package uart_req_pkg;
  typedef enum logic [1:0] {DST_NONE = 2'd0, DST_IRQ = 2'd1, DST_DMA = 2'd2} dest_e;

  typedef struct packed {
    logic       rxHit;
    logic       txHit;
    dest_e      rxDst;
    dest_e      txDst;
    logic       errClr;
    logic [3:0] errSet;
    logic       errEn;
    logic       rxReady;
    logic       txBufEmpty;
    logic       txShiftEmpty;
  } req_strobe_t;

  function automatic dest_e decodeMode(input logic [1:0] m);
    case (m)
      2'd1:    return DST_IRQ;
      2'd2:    return DST_DMA;
      default: return DST_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_req_ctrl.sv
module uart_req_ctrl
  import uart_req_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             fifoEn,
  input  logic [1:0]       rxMode,
  input  logic [1:0]       txMode,
  input  logic             errIntEn,
  input  logic [CNT_W-1:0] rxTrig,
  input  logic [CNT_W-1:0] txTrig,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] txCount,
  input  logic             rxHoldFull,
  input  logic             txHoldFull,
  input  logic             txShiftBusy,
  input  logic [3:0]       errPulse,
  input  logic             errRead,
  output req_strobe_t      strb
);
  logic rxNonEmpty;
  logic txEmpty;

  always_comb begin
    rxNonEmpty        = (rxCount != '0);
    txEmpty           = (txCount == '0);
    strb              = '0;
    strb.rxHit        = fifoEn ? (rxNonEmpty && (rxCount >= rxTrig)) : rxHoldFull;
    strb.txHit        = fifoEn ? (txCount <= txTrig) : !txHoldFull;
    strb.rxDst        = decodeMode(rxMode);
    strb.txDst        = decodeMode(txMode);
    strb.errClr       = errRead;
    strb.errSet       = errPulse;
    strb.errEn        = errIntEn;
    strb.rxReady      = fifoEn ? rxNonEmpty : rxHoldFull;
    strb.txBufEmpty   = fifoEn ? txEmpty : !txHoldFull;
    strb.txShiftEmpty = strb.txBufEmpty && !txShiftBusy;
  end
endmodule

// File: rtl/uart_req_dp.sv
module uart_req_dp
  import uart_req_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  req_strobe_t strb,
  output logic        rxIrq,
  output logic        rxDma,
  output logic        txIrq,
  output logic        txDma,
  output logic        errIrq,
  output logic [3:0]  errStatus,
  output logic        rxReady,
  output logic        txBufEmpty,
  output logic        txShiftEmpty
);
  logic [3:0] errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIrq        <= 1'b0;
      rxDma        <= 1'b0;
      txIrq        <= 1'b0;
      txDma        <= 1'b0;
      errQ         <= '0;
      rxReady      <= 1'b0;
      txBufEmpty   <= 1'b0;
      txShiftEmpty <= 1'b0;
    end else begin
      rxIrq        <= strb.rxHit && (strb.rxDst == DST_IRQ);
      rxDma        <= strb.rxHit && (strb.rxDst == DST_DMA);
      txIrq        <= strb.txHit && (strb.txDst == DST_IRQ);
      txDma        <= strb.txHit && (strb.txDst == DST_DMA);
      errQ         <= (strb.errClr ? 4'd0 : errQ) | strb.errSet;
      rxReady      <= strb.rxReady;
      txBufEmpty   <= strb.txBufEmpty;
      txShiftEmpty <= strb.txShiftEmpty;
    end
  end

  assign errStatus = errQ;
  assign errIrq    = rstN && strb.errEn && (|errQ);

  // R5: one destination per direction
  a_r5_rx_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0({rxIrq, rxDma}));
  a_r5_tx_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0({txIrq, txDma}));
  // R6: captured bits survive while no read occurs
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.errClr |=> ((errStatus & $past(errStatus)) == $past(errStatus)));
  // R6: a pulse shows up on the next clock
  a_r6_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strb.errSet != 4'd0) |=> ((errStatus & $past(strb.errSet)) == $past(strb.errSet)));
  // R7: read with no new pulses empties the register
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.errClr && strb.errSet == 4'd0) |=> (errStatus == 4'd0));
endmodule

// File: rtl/uart_req_gen.sv
module uart_req_gen
  import uart_req_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [1:0]       rxMode,
  input  logic [1:0]       txMode,
  input  logic             errIntEn,
  input  logic [CNT_W-1:0] rxTrig,
  input  logic [CNT_W-1:0] txTrig,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] txCount,
  input  logic             rxHoldFull,
  input  logic             txHoldFull,
  input  logic             txShiftBusy,
  input  logic             errOverrun,
  input  logic             errParity,
  input  logic             errFrame,
  input  logic             errBreak,
  input  logic             errRead,
  output logic             rxIrq,
  output logic             rxDma,
  output logic             txIrq,
  output logic             txDma,
  output logic             errIrq,
  output logic [3:0]       errStatus,
  output logic             rxReady,
  output logic             txBufEmpty,
  output logic             txShiftEmpty
);
  req_strobe_t strb;

  uart_req_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .fifoEn(fifoEn), .rxMode(rxMode), .txMode(txMode), .errIntEn(errIntEn),
    .rxTrig(rxTrig), .txTrig(txTrig), .rxCount(rxCount), .txCount(txCount),
    .rxHoldFull(rxHoldFull), .txHoldFull(txHoldFull), .txShiftBusy(txShiftBusy),
    .errPulse({errBreak, errFrame, errParity, errOverrun}),
    .errRead(errRead), .strb(strb)
  );

  uart_req_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxIrq(rxIrq), .rxDma(rxDma), .txIrq(txIrq), .txDma(txDma),
    .errIrq(errIrq), .errStatus(errStatus), .rxReady(rxReady),
    .txBufEmpty(txBufEmpty), .txShiftEmpty(txShiftEmpty)
  );

  // R5: disabled codes silence the direction on the next clock
  a_r5_rx_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode == 2'd0 || rxMode == 2'd3) |=> (!rxIrq && !rxDma));
  a_r5_tx_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (txMode == 2'd0 || txMode == 2'd3) |=> (!txIrq && !txDma));
  // R8: no error interrupt without its enable
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    !errIntEn |-> !errIrq);
  // R1: FIFO counts at or above trigger in interrupt mode raise the line
  a_r1_rx_fifo: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && rxMode == 2'd1 && rxCount != '0 && rxCount >= rxTrig) |=> rxIrq);
endmodule

// File: tb/uart_req_gen_bench.sv
module uart_req_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0;
  logic rstN = 0;
  logic fifoEn = 0, errIntEn = 0, rxHoldFull = 0, txHoldFull = 0, txShiftBusy = 0;
  logic [1:0] rxMode = 0, txMode = 0;
  logic [CW-1:0] rxTrig = 1, txTrig = 0, rxCount = 0, txCount = 0;
  logic errOverrun = 0, errParity = 0, errFrame = 0, errBreak = 0, errRead = 0;
  logic rxIrq, rxDma, txIrq, txDma, errIrq, rxReady, txBufEmpty, txShiftEmpty;
  logic [3:0] errStatus;

  int checks = 0;
  int failures = 0;
  logic [3:0] expErr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_req_gen #(.FIFO_DEPTH(DEPTH)) u_uart_req_gen (.*);

  function automatic bit rxCond();
    return fifoEn ? (rxCount != 0 && rxCount >= rxTrig) : rxHoldFull;
  endfunction
  function automatic bit txCond();
    return fifoEn ? (txCount <= txTrig) : !txHoldFull;
  endfunction
  function automatic bit txEmptyExp();
    return fifoEn ? (txCount == 0) : !txHoldFull;
  endfunction

  task automatic chk(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  // Expected outputs after one edge, computed from the inputs held during it
  bit eRxI, eRxD, eTxI, eTxD, eRdy, eTbe, eTse;
  task automatic predict();
    eRxI = rxCond() && rxMode == 2'd1;
    eRxD = rxCond() && rxMode == 2'd2;
    eTxI = txCond() && txMode == 2'd1;
    eTxD = txCond() && txMode == 2'd2;
    eRdy = fifoEn ? (rxCount != 0) : rxHoldFull;
    eTbe = txEmptyExp();
    eTse = eTbe && !txShiftBusy;
    expErr = (errRead ? 4'd0 : expErr) | {errBreak, errFrame, errParity, errOverrun};
  endtask

  task automatic stepCheck();
    predict();
    @(posedge clk);
    @(negedge clk);
    chk(fifoEn ? "R1" : "R3", "rxIrq", rxIrq, eRxI);
    chk("R5", "rxDma", rxDma, eRxD);
    chk(fifoEn ? "R2" : "R4", "txIrq", txIrq, eTxI);
    chk("R5", "txDma", txDma, eTxD);
    chk("R6", "errStatus", errStatus, expErr);
    chk("R8", "errIrq", errIrq, errIntEn && (expErr != 0));
    chk("R9", "rxReady", rxReady, eRdy);
    chk("R9", "txBufEmpty", txBufEmpty, eTbe);
    chk("R9", "txShiftEmpty", txShiftEmpty, eTse);
  endtask

  task automatic clearPulses();
    {errOverrun, errParity, errFrame, errBreak, errRead} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    fifoEn = 1; rxMode = 1; txMode = 2; errIntEn = 1; errOverrun = 1; txCount = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset holds everything low
    chk("R10", "outs", {rxIrq, rxDma, txIrq, txDma, errIrq, errStatus, rxReady, txBufEmpty, txShiftEmpty}, 0);
    fifoEn = 0; rxMode = 0; txMode = 0; errIntEn = 0; errOverrun = 0;
    rstN = 1;
    stepCheck();

    // R2: enable tx interrupt with empty FIFO -> request on next clock
    fifoEn = 1; txTrig = 4; txCount = 0; txMode = 1;
    stepCheck();
    chk("R2", "txIrq_empty_enable", txIrq, 1);
    txCount = 5; stepCheck();
    chk("R2", "txIrq_above_trig", txIrq, 0);
    txCount = 4; stepCheck();
    chk("R2", "txIrq_at_trig", txIrq, 1);

    // R1: receive boundary
    rxTrig = 8; rxMode = 1; rxCount = 7; stepCheck();
    chk("R1", "rxIrq_below", rxIrq, 0);
    rxCount = 8; stepCheck();
    chk("R1", "rxIrq_at", rxIrq, 1);
    rxCount = 7; stepCheck();
    chk("R1", "rxIrq_drop", rxIrq, 0);

    // R5: DMA routing and reserved code
    rxCount = 9; rxMode = 2; stepCheck();
    chk("R5", "rxDma_route", {rxIrq, rxDma}, 1);
    rxMode = 3; stepCheck();
    chk("R5", "rx_mode3", {rxIrq, rxDma}, 0);

    // R3/R4: holding register mode
    fifoEn = 0; rxMode = 1; txMode = 1; rxHoldFull = 1; txHoldFull = 1; stepCheck();
    chk("R3", "rx_hold_full", rxIrq, 1);
    chk("R4", "tx_hold_full", txIrq, 0);
    rxHoldFull = 0; txHoldFull = 0; stepCheck();
    chk("R3", "rx_hold_read", rxIrq, 0);
    chk("R4", "tx_hold_moved", txIrq, 1);

    // R6/R7/R8: capture, read with simultaneous pulse, enable gate
    errIntEn = 0; errParity = 1; stepCheck(); clearPulses();
    chk("R6", "parity_set", errStatus, 4'b0010);
    chk("R8", "gated", errIrq, 0);
    errIntEn = 1; #1;
    chk("R8", "enabled", errIrq, 1);
    errRead = 1; errBreak = 1; stepCheck(); clearPulses();
    chk("R7", "read_keeps_new", errStatus, 4'b1000);
    errRead = 1; stepCheck(); clearPulses();
    chk("R7", "read_clears", errStatus, 4'b0000);
    chk("R8", "deassert", errIrq, 0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      fifoEn = $urandom_range(0, 3) != 0;
      rxMode = 2'($urandom_range(0, 3));
      txMode = 2'($urandom_range(0, 3));
      errIntEn = $urandom_range(0, 1);
      rxTrig = CW'($urandom_range(0, DEPTH));
      txTrig = CW'($urandom_range(0, DEPTH));
      rxCount = CW'($urandom_range(0, DEPTH));
      txCount = CW'($urandom_range(0, DEPTH));
      rxHoldFull = $urandom_range(0, 1);
      txHoldFull = $urandom_range(0, 1);
      txShiftBusy = $urandom_range(0, 1);
      errOverrun = $urandom_range(0, 7) == 0;
      errParity = $urandom_range(0, 7) == 0;
      errFrame = $urandom_range(0, 7) == 0;
      errBreak = $urandom_range(0, 7) == 0;
      errRead = $urandom_range(0, 5) == 0;
      stepCheck();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule